// File: doc/BRIEF.md
# Host/Coprocessor Run Handoff Controller

This block decides which of two processors is running at any moment. A host CPU and a signal-processing coprocessor share work: the host hands a job to the coprocessor by issuing an enable command, which halts the host, releases the coprocessor and raises its interrupt. The coprocessor works, then hands control back by writing a zero word to its flag port. That write only wakes the host if the shared-memory bridge has armed an execute flag beforehand.

The coprocessor also sees a single status bit, the BIO flag, which it polls. Its flag port sets or clears this bit. A host disable command takes the coprocessor off the bus again, by halting it and dropping its interrupt, without touching the host halt. Command and port decoding happens in the same cycle as the strobe. Every output is a register, so an effect shows on the clock edge after the strobe is sampled. The active-low reset is applied asynchronously and is released through a two-stage synchronizer.

Top module: `handoff_ctrl`

## Requirements
- R1: During reset and after it, with no strobes, `host_halt`=0, `cop_halt`=1, `cop_irq`=0, `cop_enabled`=0, `bio_active`=0 and `exec_pending`=0.
- R2: A host write (`host_we`=1) of 0x0C gives `cop_halt`=0, `cop_irq`=1, `host_halt`=1 and `cop_enabled`=1 on the next cycle.
- R3: A host write of 0x0D gives `cop_halt`=1, `cop_irq`=0 and `cop_enabled`=0 on the next cycle, and leaves `host_halt` unchanged.
- R4: A host write of any other value, or any cycle with `host_we`=0, changes none of `host_halt`, `cop_halt`, `cop_irq` or `cop_enabled`.
- R5: A flag-port write (`bio_we`=1) whose bit 15 is 1 gives `bio_active`=0 on the next cycle.
- R6: A flag-port write of exactly 0x0000 gives `bio_active`=1 on the next cycle.
- R7: A nonzero flag-port write with bit 15 at 0 leaves `bio_active`, `exec_pending` and `host_halt` unchanged.
- R8: A 0x0000 flag-port write while `exec_pending`=1 gives `host_halt`=0 and `exec_pending`=0 on the next cycle. The same write with `exec_pending`=0 leaves `host_halt` unchanged.
- R9: A bridge strobe (`xfer_we`=1) loads `exec_pending` with `xfer_arm` on the next cycle.
- R10: When a host 0x0C write and a waking flag-port write fall in the same cycle, the host is halted (`host_halt`=1), and the execute flag is still consumed.
- R11: When a bridge strobe and a waking flag-port write fall in the same cycle, the wake uses the previous flag, and `exec_pending` takes the new `xfer_arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host control-register write strobe |
| host_data | input | 8 | Host control value |
| bio_we | input | 1 | Coprocessor flag-port write strobe |
| bio_data | input | 16 | Coprocessor flag-port value |
| xfer_we | input | 1 | Bridge write strobe that updates the execute flag |
| xfer_arm | input | 1 | Execute-flag value presented by the bridge |
| host_halt | output | 1 | Halt line to the host CPU |
| cop_halt | output | 1 | Halt line to the coprocessor |
| cop_irq | output | 1 | Interrupt line to the coprocessor |
| cop_enabled | output | 1 | Stored coprocessor-enabled state |
| bio_active | output | 1 | BIO status bit polled by the coprocessor |
| exec_pending | output | 1 | Execute flag waiting to be consumed |

## Verification
Two things can land on the host halt register in the same cycle: the host enable command sets it, and the coprocessor's waking zero write clears it. The bench forces this collision in directed vectors and lets it arise in the random stream. It predicts that the host stays halted while the execute flag is still used up. A second collision puts a bridge strobe next to a waking write, and the bench checks that the wake reads the old flag while the stored flag takes the new value.

// File: rtl/handoff_pkg.sv
package handoff_pkg;
  typedef enum logic [1:0] {
    HCMD_NONE    = 2'd0,
    HCMD_ENABLE  = 2'd1,
    HCMD_DISABLE = 2'd2
  } host_cmd_e;
endpackage

// File: rtl/handoff_cmd_dec.sv
module handoff_cmd_dec
  import handoff_pkg::*;
#(
  parameter int          CTL_W    = 8,
  parameter logic [CTL_W-1:0] EN_CODE  = 8'h0C,
  parameter logic [CTL_W-1:0] DIS_CODE = 8'h0D
) (
  input  logic             host_we,
  input  logic [CTL_W-1:0] host_data,
  output host_cmd_e        cmd
);
  always_comb begin
    cmd = HCMD_NONE;
    if (host_we) begin
      if (host_data == EN_CODE)       cmd = HCMD_ENABLE;
      else if (host_data == DIS_CODE) cmd = HCMD_DISABLE;
    end
  end
endmodule

// File: rtl/handoff_bio_reg.sv
module handoff_bio_reg #(
  parameter int BIO_W   = 16,
  parameter int CLR_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bio_we,
  input  logic [BIO_W-1:0] bio_data,
  input  logic             xfer_we,
  input  logic             xfer_arm,
  output logic             bio_active,
  output logic             exec_pending,
  output logic             wake
);
  logic bio_q, bio_d;
  logic pend_q, pend_d;
  logic zero_wr;
  logic upd_en;

  assign zero_wr = bio_we && (bio_data == '0);
  assign wake    = zero_wr && pend_q;
  assign upd_en  = bio_we || xfer_we;

  always_comb begin
    bio_d  = bio_q;
    pend_d = pend_q;
    if (bio_we && bio_data[CLR_BIT]) bio_d = 1'b0;
    if (zero_wr)                     bio_d = 1'b1;
    if (wake)                        pend_d = 1'b0;
    if (xfer_we)                     pend_d = xfer_arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bio_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      bio_q  <= bio_d;
      pend_q <= pend_d;
    end
  end

  assign bio_active   = bio_q;
  assign exec_pending = pend_q;

  // R6
  zero_sets_bio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> bio_active);
  // R5
  clr_bit_drops_bio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bio_we && bio_data[CLR_BIT]) |=> !bio_active);
  // R8
  wake_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !xfer_we) |=> !exec_pending);
  // R9
  bridge_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_we |=> (exec_pending == $past(xfer_arm)));
endmodule

// File: rtl/handoff_run_ctl.sv
module handoff_run_ctl
  import handoff_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  host_cmd_e cmd,
  input  logic      wake,
  output logic      host_halt,
  output logic      cop_halt,
  output logic      cop_irq,
  output logic      cop_enabled
);
  logic en_q, en_d;
  logic irq_q, irq_d;
  logic chalt_q, chalt_d;
  logic hhalt_q, hhalt_d;
  logic upd_en;

  assign upd_en = (cmd != HCMD_NONE) || wake;

  always_comb begin
    en_d    = en_q;
    irq_d   = irq_q;
    chalt_d = chalt_q;
    hhalt_d = hhalt_q;
    if (wake) hhalt_d = 1'b0;
    case (cmd)
      HCMD_ENABLE: begin
        en_d    = 1'b1;
        irq_d   = 1'b1;
        chalt_d = 1'b0;
        hhalt_d = 1'b1;
      end
      HCMD_DISABLE: begin
        en_d    = 1'b0;
        irq_d   = 1'b0;
        chalt_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      chalt_q <= 1'b1;
      hhalt_q <= 1'b0;
    end else if (upd_en) begin
      en_q    <= en_d;
      irq_q   <= irq_d;
      chalt_q <= chalt_d;
      hhalt_q <= hhalt_d;
    end
  end

  assign host_halt   = hhalt_q;
  assign cop_halt    = chalt_q;
  assign cop_irq     = irq_q;
  assign cop_enabled = en_q;

  // R2
  enable_halts_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == HCMD_ENABLE) |=> (host_halt && cop_irq && !cop_halt));
  // R3
  disable_keeps_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == HCMD_DISABLE && !wake) |=> (cop_halt && !cop_irq && $stable(host_halt)));
  // R8
  wake_frees_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && cmd != HCMD_ENABLE) |=> !host_halt);
  // R1
  halt_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cop_halt && cop_irq));
endmodule

// File: rtl/handoff_ctrl.sv
module handoff_ctrl
  import handoff_pkg::*;
#(
  parameter int               CTL_W    = 8,
  parameter logic [CTL_W-1:0] EN_CODE  = 8'h0C,
  parameter logic [CTL_W-1:0] DIS_CODE = 8'h0D,
  parameter int               BIO_W    = 16,
  parameter int               SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [CTL_W-1:0] host_data,
  input  logic             bio_we,
  input  logic [BIO_W-1:0] bio_data,
  input  logic             xfer_we,
  input  logic             xfer_arm,
  output logic             host_halt,
  output logic             cop_halt,
  output logic             cop_irq,
  output logic             cop_enabled,
  output logic             bio_active,
  output logic             exec_pending
);
  localparam int CLR_BIT = BIO_W - 1;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  host_cmd_e         cmd;
  logic              wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  handoff_cmd_dec #(
    .CTL_W(CTL_W), .EN_CODE(EN_CODE), .DIS_CODE(DIS_CODE)
  ) dec_i (
    .host_we(host_we), .host_data(host_data), .cmd(cmd)
  );

  handoff_bio_reg #(
    .BIO_W(BIO_W), .CLR_BIT(CLR_BIT)
  ) bio_i (
    .clk(clk), .rst_n(rst_int_n), .bio_we(bio_we), .bio_data(bio_data),
    .xfer_we(xfer_we), .xfer_arm(xfer_arm), .bio_active(bio_active),
    .exec_pending(exec_pending), .wake(wake)
  );

  handoff_run_ctl run_i (
    .clk(clk), .rst_n(rst_int_n), .cmd(cmd), .wake(wake),
    .host_halt(host_halt), .cop_halt(cop_halt), .cop_irq(cop_irq),
    .cop_enabled(cop_enabled)
  );

  // R10
  collide_enable_wins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd == HCMD_ENABLE && wake) |=> host_halt);
endmodule

// File: tb/handoff_ctrl_tb.sv
module handoff_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [7:0]  host_data;
  logic        bio_we;
  logic [15:0] bio_data;
  logic        xfer_we;
  logic        xfer_arm;
  logic        host_halt, cop_halt, cop_irq, cop_enabled, bio_active, exec_pending;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic m_host, m_coph, m_irq, m_en, m_bio, m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  handoff_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_data(host_data),
    .bio_we(bio_we), .bio_data(bio_data), .xfer_we(xfer_we), .xfer_arm(xfer_arm),
    .host_halt(host_halt), .cop_halt(cop_halt), .cop_irq(cop_irq),
    .cop_enabled(cop_enabled), .bio_active(bio_active), .exec_pending(exec_pending)
  );

  function automatic logic [5:0] pack_model();
    return {m_host, m_coph, m_irq, m_en, m_bio, m_pend};
  endfunction

  function automatic string pick_tag(logic hw, logic [7:0] hd, logic bw,
                                     logic [15:0] bd, logic xw, logic pend);
    logic wk;
    wk = bw && (bd == 16'h0000) && pend;
    if (hw && hd == 8'h0C && wk) return "R10";
    if (xw && wk)                return "R11";
    if (wk)                      return "R8";
    if (hw && hd == 8'h0C)       return "R2";
    if (hw && hd == 8'h0D)       return "R3";
    if (bw && bd == 16'h0000)    return "R6";
    if (bw && bd[15])            return "R5";
    if (bw)                      return "R7";
    if (xw)                      return "R9";
    return "R4";
  endfunction

  task automatic model_step(logic hw, logic [7:0] hd, logic bw,
                            logic [15:0] bd, logic xw, logic xa);
    logic wk;
    wk = bw && (bd == 16'h0000) && m_pend;
    if (wk) m_host = 1'b0;
    if (hw && hd == 8'h0C) begin
      m_en = 1'b1; m_irq = 1'b1; m_coph = 1'b0; m_host = 1'b1;
    end else if (hw && hd == 8'h0D) begin
      m_en = 1'b0; m_irq = 1'b0; m_coph = 1'b1;
    end
    if (bw && bd[15])          m_bio = 1'b0;
    if (bw && bd == 16'h0000)  m_bio = 1'b1;
    if (wk) m_pend = 1'b0;
    if (xw) m_pend = xa;
  endtask

  task automatic check(string tag);
    logic [5:0] act;
    act = {host_halt, cop_halt, cop_irq, cop_enabled, bio_active, exec_pending};
    n_vec++;
    if (act !== pack_model()) begin
      n_bad++;
      $display("FAIL %s: {host_halt,cop_halt,cop_irq,cop_enabled,bio_active,exec_pending} actual=%b expected=%b",
               tag, act, pack_model());
    end
  endtask

  task automatic apply(logic hw, logic [7:0] hd, logic bw, logic [15:0] bd,
                       logic xw, logic xa, string tag);
    string t;
    t = (tag == "") ? pick_tag(hw, hd, bw, bd, xw, m_pend) : tag;
    host_we = hw; host_data = hd; bio_we = bw; bio_data = bd;
    xfer_we = xw; xfer_arm = xa;
    model_step(hw, hd, bw, bd, xw, xa);
    @(negedge clk);
    check(t);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    host_we = 0; host_data = 0; bio_we = 0; bio_data = 0; xfer_we = 0; xfer_arm = 0;
    m_host = 0; m_coph = 1; m_irq = 0; m_en = 0; m_bio = 0; m_pend = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");

    // Directed corner cases
    apply(1, 8'h0C, 0, 16'h0000, 0, 0, "R2");
    apply(1, 8'h0E, 0, 16'h0000, 0, 0, "R4");
    apply(0, 8'h0D, 0, 16'h0000, 0, 0, "R4");
    apply(0, 8'h00, 1, 16'h0000, 0, 0, "R6");
    apply(0, 8'h00, 1, 16'h0000, 0, 0, "R8");
    apply(0, 8'h00, 1, 16'h8000, 0, 0, "R5");
    apply(0, 8'h00, 0, 16'h0000, 1, 1, "R9");
    apply(0, 8'h00, 1, 16'h7FFF, 0, 0, "R7");
    apply(0, 8'h00, 1, 16'h0001, 0, 0, "R7");
    apply(0, 8'h00, 1, 16'h0000, 0, 0, "R8");
    apply(1, 8'h0C, 0, 16'h0000, 1, 1, "R2");
    apply(1, 8'h0D, 0, 16'h0000, 0, 0, "R3");
    apply(1, 8'h0C, 1, 16'h0000, 0, 0, "R10");
    apply(0, 8'h00, 0, 16'h0000, 1, 1, "R9");
    apply(0, 8'h00, 1, 16'h0000, 1, 1, "R11");
    apply(0, 8'h00, 1, 16'h0000, 1, 0, "R11");
    apply(0, 8'h00, 1, 16'hFFFF, 1, 0, "R9");
    apply(1, 8'h0D, 0, 16'h0000, 0, 0, "R3");

    // Constrained random stream
    for (int i = 0; i < 2000; i++) begin
      logic        hw, bw, xw, xa;
      logic [7:0]  hd;
      logic [15:0] bd;
      int          sel;
      hw  = ($urandom_range(0, 3) == 0);
      sel = $urandom_range(0, 3);
      hd  = (sel == 0) ? 8'h0C : (sel == 1) ? 8'h0D : 8'($urandom);
      bw  = ($urandom_range(0, 2) == 0);
      sel = $urandom_range(0, 3);
      bd  = (sel == 0) ? 16'h0000 : (sel == 1) ? (16'h8000 | 16'($urandom))
          : (sel == 2) ? (16'h7FFF & 16'($urandom)) : 16'($urandom);
      xw  = ($urandom_range(0, 3) == 0);
      xa  = ($urandom_range(0, 2) != 0);
      apply(hw, hd, bw, bd, xw, xa, "");
    end

    apply(0, 8'h00, 0, 16'h0000, 0, 0, "R4");
    finish_run();
  end
endmodule